// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits on a plain 32-bit register bus with single-cycle read and write strobes. Software sets a coarse reload field and a prescaler choice, then enables the timer. From then on it must write a fixed magic word to the restart register often enough to keep a down-counter from reaching zero. If the counter runs out, the block latches an expiry flag. Depending on how it was set up, it then holds an interrupt level or emits a reset pulse of fixed length.

Stray writes are guarded against. The mode and counter-control registers each accept a write only when a register-specific key sits in the upper bits of the write word. The restart register acts only on one exact 32-bit value. The reload value is a 12-bit field followed by SCALE_BITS zero bits, which is 12 by default. The counter steps once per prescaled tick. Registers are decoded on address bits [3:2]: mode at 0x0, counter-control at 0x4, restart at 0x8 and status at 0xC.

Top module: `key_wdt`

## Requirements
- R1: A write to the mode register (offset 0x0) is taken only when write-data bits [23:12] equal 0xABC; otherwise the mode register keeps its contents.
- R2: A write to the counter-control register (offset 0x4) is taken only when write-data bits [25:14] equal 0x248; otherwise the register keeps its contents.
- R3: Mode bit 0 enables counting, bit 1 enables the reset pulse on expiry, bit 2 enables the interrupt level, and bits [5:4] hold the pulse-length code.
- R4: Counter-control bits [13:2] hold the 12-bit reload field. Bits [1:0] pick the tick divisor: 0 gives 8, 1 gives 64, 2 gives 512 and 3 gives 4096 bus clocks per tick. The prescaler restarts from zero on every reload.
- R5: A reload sets the counter to the field shifted left by SCALE_BITS. While enabled and not expired, the counter drops by one per tick. In the cycle where an enabled, unexpired counter is zero, the expiry flag is set at the next edge. A field of zero expires at once.
- R6: Writing exactly 0x00001999 to the restart register (offset 0x8) reloads the counter and clears the expiry flag. Any other value written there changes nothing.
- R7: A keyed mode write that turns enable from 0 to 1 reloads the counter. A keyed write that clears enable freezes the counter, so no expiry can follow.
- R8: Status bit 0 (offset 0xC) reads the expiry flag. The interrupt output equals the flag AND the interrupt-enable bit.
- R9: If the reset enable is set when the flag is set, the reset output goes high for 2^(code+1) bus clocks, starting one cycle later. Code 3 therefore gives 16 cycles.
- R10: With the read strobe high, reads return the stored fields with all key bits as zero. The restart register reads zero. Writes to the status register have no effect. With the read strobe low, the read data is zero.
- R11: After reset, mode reads 0, counter-control reads 0x3FFF (field 0xFFF, select 3), status reads 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | ADDR_W | Byte address; bits [3:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| wdt_irq | output | 1 | Expiry interrupt level |
| wdt_rst | output | 1 | Expiry reset pulse |

## Verification
The timer runs against a bench model under several patterns:
- **Unserviced expiry.** Each of the four divisors is used, plus a zero reload field. This separates the divisor decode and the shift of the reload field.
- **Regular kicks before the deadline.** This shows that restarts really reload the counter.
- **Near-miss writes.** Wrong keys and a restart word off by one bit separate guarded writes from accepted ones.
- **Mid-count disable.** This checks the freeze.
- **Two pulse-length codes.** This checks the stretch count.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the key-protected watchdog.
// Assumes a 32-bit bus and word registers decoded on address bits [3:2].
package wdt_pkg;
    localparam int          RELOAD_W     = 12;
    localparam logic [11:0] MODE_KEY     = 12'hABC;
    localparam logic [11:0] CTRL_KEY     = 12'h248;
    localparam logic [31:0] KICK_WORD    = 32'h0000_1999;

    typedef enum logic [1:0] {
        SLOT_MODE  = 2'd0,
        SLOT_CTRL  = 2'd1,
        SLOT_KICK  = 2'd2,
        SLOT_STAT  = 2'd3
    } wdt_slot_e;

    typedef struct packed {
        logic [1:0] len_code;
        logic       irq_on;
        logic       rst_on;
        logic       run_on;
    } wdt_mode_t;
endpackage

// File: rtl/wdt_regs.sv
// Register file and bus decode for the watchdog.
// Holds the mode and counter-control fields behind their keys, turns the
// magic word into a kick strobe, and forms the read data.
// Assumes single-cycle strobes and at least a 4-bit byte address.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                rd,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    input  logic                expired,
    output wdt_mode_t           mode,
    output logic [RELOAD_W-1:0] reload_fld,
    output logic [1:0]          div_sel,
    output logic                kick,
    output logic                run_rise,
    output logic [31:0]         rdata
);
    wdt_slot_e slot;
    logic      mode_take, ctrl_take;

    assign slot      = wdt_slot_e'(addr[3:2]);
    assign mode_take = wr && slot == SLOT_MODE && wdata[23:12] == MODE_KEY;
    assign ctrl_take = wr && slot == SLOT_CTRL && wdata[25:14] == CTRL_KEY;
    assign kick      = wr && slot == SLOT_KICK && wdata == KICK_WORD;
    assign run_rise  = mode_take && wdata[0] && !mode.run_on;

    // Keyed register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= '0;
            reload_fld <= '1;
            div_sel    <= 2'd3;
        end else begin
            if (mode_take)
                mode <= '{len_code: wdata[5:4], irq_on: wdata[2],
                          rst_on: wdata[1], run_on: wdata[0]};
            if (ctrl_take) begin
                reload_fld <= wdata[13:2];
                div_sel    <= wdata[1:0];
            end
        end
    end

    // Read multiplexer, key bits always zero
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (slot)
                SLOT_MODE: rdata[5:0]  = {mode.len_code, 1'b0, mode.irq_on,
                                          mode.rst_on, mode.run_on};
                SLOT_CTRL: rdata[13:0] = {reload_fld, div_sel};
                SLOT_KICK: rdata       = '0;
                SLOT_STAT: rdata[0]    = expired;
            endcase
        end
    end

    assert_mode_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && slot == SLOT_MODE && wdata[23:12] != MODE_KEY) |=> $stable(mode));
    assert_ctrl_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && slot == SLOT_CTRL && wdata[25:14] != CTRL_KEY)
        |=> ($stable(reload_fld) && $stable(div_sel)));
endmodule

// File: rtl/wdt_prescaler.sv
// Tick generator: divides the bus clock by 2^(STEP*(sel+1)).
// Restarts from zero on clear; counts only while run is high.
module wdt_prescaler #(
    parameter int STEP  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PS_W = STEP * (2 ** SEL_W);

    logic [PS_W-1:0] ps_q, lim;

    // Terminal count mask for the selected divisor
    always_comb begin
        for (int i = 0; i < PS_W; i++)
            lim[i] = (i < STEP * (int'(sel) + 1));
    end

    assign tick = run && (ps_q >= lim);

    // Prescale counter
    always_ff @(posedge clk) begin
        if (!rst_n)      ps_q <= '0;
        else if (clear)  ps_q <= '0;
        else if (run)    ps_q <= tick ? '0 : ps_q + 1'b1;
    end

    assert_tick_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (ps_q == '0));
endmodule

// File: rtl/wdt_counter.sv
// Down-counter and expiry flag.
// Loads reload_fld << SCALE_BITS, steps on tick, and sets the sticky flag
// one edge after reaching zero; the flag clears only on a kick.
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int SCALE_BITS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tick,
    input  logic                reload,
    input  logic                kick,
    input  logic [RELOAD_W-1:0] reload_fld,
    output logic                expire,
    output logic                expired
);
    localparam int CNT_W = RELOAD_W + SCALE_BITS;

    logic [CNT_W-1:0] cnt_q;

    assign expire = enable && !expired && cnt_q == '0 && !reload;

    // Counter load and step
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= {reload_fld, {SCALE_BITS{1'b0}}};
        else if (enable && !expired && tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Sticky expiry flag
    always_ff @(posedge clk) begin
        if (!rst_n)      expired <= 1'b0;
        else if (kick)   expired <= 1'b0;
        else if (expire) expired <= 1'b1;
    end

    assert_expire_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> ($past(cnt_q) == '0));
    assert_frozen_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_pulse.sv
// Reset-pulse stretcher: on start, holds active for 2^(code+1) cycles.
module wdt_pulse #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              active
);
    localparam int LEN_W = 2 ** CODE_W + 1;

    logic [LEN_W-1:0] left_q, len;

    // Pulse length from the code
    always_comb begin
        len = '0;
        len[int'(code) + 1] = 1'b1;
    end

    // Remaining pulse cycles
    always_ff @(posedge clk) begin
        if (!rst_n)             left_q <= '0;
        else if (start)         left_q <= len;
        else if (left_q != '0)  left_q <= left_q - 1'b1;
    end

    assign active = left_q != '0;

    assert_pulse_after_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(start));
endmodule

// File: rtl/key_wdt.sv
// Key-protected watchdog top: wires registers, prescaler, down-counter and
// reset-pulse stretcher. Assumes the bus and the timer share clk.
module key_wdt
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int SCALE_BITS = 12,
    parameter int PRE_STEP   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_irq,
    output logic              wdt_rst
);
    wdt_mode_t           mode;
    logic [RELOAD_W-1:0] reload_fld;
    logic [1:0]          div_sel;
    logic                kick, run_rise, reload, tick, expire, expired;

    assign reload = kick || run_rise;

    wdt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .expired(expired), .mode(mode),
        .reload_fld(reload_fld), .div_sel(div_sel), .kick(kick),
        .run_rise(run_rise), .rdata(bus_rdata)
    );

    wdt_prescaler #(.STEP(PRE_STEP), .SEL_W(2)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(mode.run_on && !expired),
        .clear(reload), .sel(div_sel), .tick(tick)
    );

    wdt_counter #(.SCALE_BITS(SCALE_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .enable(mode.run_on), .tick(tick),
        .reload(reload), .kick(kick), .reload_fld(reload_fld),
        .expire(expire), .expired(expired)
    );

    wdt_pulse #(.CODE_W(2)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(expire && mode.rst_on),
        .code(mode.len_code), .active(wdt_rst)
    );

    assign wdt_irq = expired && mode.irq_on;

    assert_kick_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !expired);
    assert_flag_drop_needs_kick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(expired) |-> $past(kick));
endmodule

// File: tb/test_key_wdt.sv
// Bench: behavioural reference model compared on every clock.
module test_key_wdt;
    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq, wdt_rst;

    int checks = 0, fails = 0, cycles = 0;

    // Model state
    int m_en, m_rsten, m_irqen, m_len, m_fld, m_sel, m_cnt, m_ps, m_flag, m_pulse;

    key_wdt #(.ADDR_W(4), .SCALE_BITS(S), .PRE_STEP(3)) i_key_wdt (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    always #10 clk = ~clk;

    function automatic int divisor(int sel);
        return 1 << (3 * (sel + 1));
    endfunction

    // Reference model: updates per spec on every rising edge
    always @(posedge clk) begin
        int slot;
        bit mode_ok, ctrl_ok, kick_ok, rise, reload, run, tick, expire;
        if (!rst_n) begin
            m_en = 0; m_rsten = 0; m_irqen = 0; m_len = 0;
            m_fld = 12'hFFF; m_sel = 3; m_cnt = 0; m_ps = 0; m_flag = 0; m_pulse = 0;
        end else begin
            slot    = int'(bus_addr[3:2]);
            mode_ok = bus_wr && slot == 0 && bus_wdata[23:12] == 12'hABC;
            ctrl_ok = bus_wr && slot == 1 && bus_wdata[25:14] == 12'h248;
            kick_ok = bus_wr && slot == 2 && bus_wdata == 32'h1999;
            rise    = mode_ok && bus_wdata[0] && m_en == 0;
            reload  = kick_ok || rise;
            run     = m_en != 0 && m_flag == 0;
            tick    = run && m_ps >= divisor(m_sel) - 1;
            expire  = m_en != 0 && m_flag == 0 && m_cnt == 0 && !reload;
            if (expire && m_rsten != 0) m_pulse = 2 << m_len;
            else if (m_pulse > 0)       m_pulse = m_pulse - 1;
            if (kick_ok)     m_flag = 0;
            else if (expire) m_flag = 1;
            if (reload) begin
                m_cnt = m_fld << S; m_ps = 0;
            end else begin
                if (m_en != 0 && tick && m_cnt != 0) m_cnt = m_cnt - 1;
                if (run) m_ps = tick ? 0 : m_ps + 1;
            end
            if (mode_ok) begin
                m_en = bus_wdata[0]; m_rsten = bus_wdata[1];
                m_irqen = bus_wdata[2]; m_len = int'(bus_wdata[5:4]);
            end
            if (ctrl_ok) begin
                m_fld = int'(bus_wdata[13:2]); m_sel = int'(bus_wdata[1:0]);
            end
        end
    end

    function automatic logic [31:0] exp_read(int slot);
        case (slot)
            0: return 32'(m_len * 16 + m_irqen * 4 + m_rsten * 2 + m_en);
            1: return 32'(m_fld * 4 + m_sel);
            2: return 32'h0;
            default: return 32'(m_flag);
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Outputs compared on every falling edge (R8 interrupt, R9 reset pulse)
    always @(negedge clk) begin
        if (rst_n) begin
            check(wdt_irq == (m_flag != 0 && m_irqen != 0), "R8 irq",
                  32'(wdt_irq), 32'(m_flag != 0 && m_irqen != 0));
            check(wdt_rst == (m_pulse > 0), "R9 rst", 32'(wdt_rst), 32'(m_pulse > 0));
        end
    end

    // Watchdog for the run itself
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic bus_write(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic read_check(logic [3:0] a, string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(bus_rdata == exp_read(int'(a[3:2])), req, bus_rdata, exp_read(int'(a[3:2])));
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        check(bus_rdata == 32'h0, "R10 idle read", bus_rdata, 32'h0);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(5);
        @(negedge clk) rst_n = 1'b1;
        // R11 reset state
        read_check(4'h0, "R11 mode reset");
        read_check(4'h4, "R11 ctrl reset 0x3FFF");
        check(exp_read(1) == 32'h3FFF, "R11 model", exp_read(1), 32'h3FFF);
        read_check(4'hC, "R11 status reset");
        read_check(4'h8, "R10 kick reads zero");
        // R2 unkeyed control write ignored, then keyed write: field 3, div 8
        bus_write(4'h4, 32'h0000_000D);
        read_check(4'h4, "R2 unkeyed ctrl ignored");
        bus_write(4'h4, 32'h0092_000C);
        read_check(4'h4, "R4 R10 ctrl fields, key reads zero");
        // R1 unkeyed mode write ignored
        bus_write(4'h0, 32'h0000_0007);
        read_check(4'h0, "R1 unkeyed mode ignored");
        idle(20);
        // R3 R7 enable with interrupt: reload 12, expiry after 96 cycles
        bus_write(4'h0, 32'h00AB_C005);
        read_check(4'h0, "R3 mode fields");
        idle(110);
        read_check(4'hC, "R8 status set after expiry");
        // R6 near-miss kick ignored, then valid kick
        bus_write(4'h8, 32'h0000_1998);
        idle(5);
        read_check(4'hC, "R6 wrong kick ignored");
        bus_write(4'h8, 32'h0000_1999);
        read_check(4'hC, "R6 kick clears flag");
        for (int k = 0; k < 4; k++) begin
            idle(60);
            bus_write(4'h8, 32'h0000_1999);
        end
        read_check(4'hC, "R6 regular kicks prevent expiry");
        // R9 reset pulse, code 3 (16 cycles)
        bus_write(4'h0, 32'h00AB_C033);
        bus_write(4'h8, 32'h0000_1999);
        idle(130);
        read_check(4'hC, "R9 flag after reset-mode expiry");
        // R9 code 0 (2 cycles)
        bus_write(4'h0, 32'h00AB_C003);
        bus_write(4'h8, 32'h0000_1999);
        idle(120);
        // R10 status is read-only
        bus_write(4'hC, 32'h0000_0000);
        read_check(4'hC, "R10 status write ignored");
        // R4 divisor 64, field 1: 256 cycles
        bus_write(4'h4, 32'h0092_0005);
        bus_write(4'h0, 32'h00AB_C005);
        bus_write(4'h8, 32'h0000_1999);
        idle(300);
        read_check(4'hC, "R4 div 64 expiry");
        // R5 zero field expires at once
        bus_write(4'h4, 32'h0092_0000);
        bus_write(4'h8, 32'h0000_1999);
        idle(5);
        read_check(4'hC, "R5 zero field expiry");
        // R7 disable mid-count freezes
        bus_write(4'h4, 32'h0092_000C);
        bus_write(4'h8, 32'h0000_1999);
        idle(40);
        bus_write(4'h0, 32'h00AB_C004);
        idle(200);
        read_check(4'hC, "R7 disabled counter frozen");
        bus_write(4'h0, 32'h00AB_C005);
        idle(110);
        read_check(4'hC, "R7 re-enable reloads then expires");
        // R4 divisor 4096, field 1: 16384 cycles
        bus_write(4'h4, 32'h0092_0007);
        bus_write(4'h8, 32'h0000_1999);
        idle(16300);
        read_check(4'hC, "R4 div 4096 not yet expired");
        idle(120);
        read_check(4'hC, "R4 div 4096 expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule